// File: doc/BRIEF.md
# Data-Link Message Serial Transmitter

This block sends one stored data-link message as a bit-oriented HDLC stream. The message is first written into a small internal byte memory through a byte-write port. A start command then launches one transmission. The block sends an opening flag, then the message bytes least significant bit first, then a 16-bit frame check sequence, then a closing flag. Zero insertion is applied to the message and check-sequence fields. Between messages the line carries continuous flags.

The output advances by one bit for each request strobe from the frame generator that carries the stream. The generator can therefore space its bit requests as its own frame layout demands. A message is either 76 or 82 bytes long, chosen by a control input when the start is accepted. The block raises a one-cycle completion interrupt after the last bit of the closing flag has been taken. Placing the bits into a particular overhead position is left to the frame generator.

Top module: `lapd_tx`

## Requirements
- R1: After reset the block is idle: `busy_o` and `done_irq_o` are low, and `bit_o` shows bit 0 of a flag, which is 0.
- R2: While idle, successive request strobes take the flag octet 0x7E, bit 0 first (0,1,1,1,1,1,1,0), repeated without a gap.
- R3: A `start_i` pulse while idle sets `busy_o` high in the next cycle. The stream then restarts with one complete flag, followed by the message bytes from address 0 upward, each byte bit 0 first.
- R4: `len_sel_i` is sampled when the start is accepted: 1 selects 82 message bytes, 0 selects 76. Later changes to it have no effect on the message in progress.
- R5: After the message, the block sends the check sequence. The register is preset to 0xFFFF and updated per message bit with the reflected polynomial x^16+x^12+x^5+1 (shift right, XOR with 0x8408 when bit 0 of the register differs from the data bit). The complement of the final register is sent bit 0 first.
- R6: After any five consecutive ones within the message and check-sequence fields, a 0 is inserted. This includes a 0 needed right after the last check-sequence bit, before the closing flag. No 0 is ever inserted inside a flag.
- R7: A closing flag follows the check sequence. In the cycle after the strobe that takes its last bit, `done_irq_o` is high for exactly one cycle and `busy_o` is low. Idle flags then resume from bit 0.
- R8: `bit_o` changes only on a clock edge where `bit_req_i` or an accepted start is present. Without a strobe it holds, so any pause between strobes is tolerated.
- R9: A `start_i` pulse while `busy_o` is high is ignored, and the message in progress continues unchanged.
- R10: A memory write while `busy_o` is high is discarded, so the stored byte keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Message byte write enable |
| wr_addr_i | input | AW (7) | Message byte address |
| wr_data_i | input | 8 | Message byte data |
| len_sel_i | input | 1 | Message length select: 1 = 82 bytes, 0 = 76 bytes |
| start_i | input | 1 | Start one message transmission |
| bit_req_i | input | 1 | Bit request strobe from the frame generator |
| bit_o | output | 1 | Current serial bit, taken on the next strobe |
| busy_o | output | 1 | A message is in transmission |
| done_irq_o | output | 1 | One-cycle pulse when a message has completed |

## Verification
The hardest situation to reach from the ports is a run of five ones that ends exactly on the last check-sequence bit. That case forces a stuffed 0 between the check sequence and the closing flag. Which message contents produce it depends on the CRC, so random messages rarely hit it. The bench keeps its own bit-level CRC and stuffing model. It tries all 256 values of the final message byte and picks one whose stuffed tail ends with that forced insertion before loading and sending the message. Other frames use all-ones data for dense stuffing, random gaps between strobes, and start and write pulses inside the opening flag.

// File: rtl/lapd_tx_pkg.sv
package lapd_tx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OPEN,
    ST_DATA,
    ST_CRC,
    ST_CLOSE
  } tx_state_e;

  localparam logic [7:0]  FLAG_OCTET = 8'h7E;
  localparam logic [15:0] CRC_PRESET = 16'hFFFF;
  localparam logic [15:0] CRC_POLY_R = 16'h8408;  // x^16+x^12+x^5+1, reflected
endpackage

// File: rtl/lapd_msg_ram.sv
module lapd_msg_ram #(
  parameter int AW = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic          blk_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [7:0]    wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [7:0]    rdata_o
);
  localparam int DEPTH = 1 << AW;

  logic [7:0] mem_q [DEPTH];
  logic [7:0] wr_tgt;

  always_ff @(posedge clk_i) begin
    if (we_i && !blk_i) mem_q[waddr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[raddr_i];
  assign wr_tgt  = mem_q[waddr_i];

  // R10: blocked write leaves the addressed byte untouched
  a_r10_write_blocked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && blk_i) |=> mem_q[$past(waddr_i)] == $past(wr_tgt));
endmodule

// File: rtl/lapd_crc16.sv
module lapd_crc16
  import lapd_tx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic init_i,
  input  logic upd_i,
  input  logic bit_i,
  input  logic shift_i,
  output logic fcs_bit_o
);
  logic [15:0] crc_q, crc_nxt;

  always_comb begin
    crc_nxt = {1'b0, crc_q[15:1]};
    if (crc_q[0] ^ bit_i) crc_nxt = crc_nxt ^ CRC_POLY_R;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      crc_q <= CRC_PRESET;
    else if (init_i)  crc_q <= CRC_PRESET;
    else if (upd_i)   crc_q <= crc_nxt;
    else if (shift_i) crc_q <= {1'b0, crc_q[15:1]};
  end

  assign fcs_bit_o = ~crc_q[0];

  a_r5_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    init_i |=> crc_q == CRC_PRESET);
  a_r5_no_overlap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(upd_i && shift_i));
endmodule

// File: rtl/lapd_zero_stuff.sv
module lapd_zero_stuff #(
  parameter int RUN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic upd_i,
  input  logic bit_i,
  output logic stuff_o
);
  localparam int CW = $clog2(RUN + 1);

  logic [CW-1:0] ones_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ones_q <= '0;
    else if (clr_i)  ones_q <= '0;
    else if (upd_i)  ones_q <= bit_i ? ones_q + 1'b1 : '0;
  end

  assign stuff_o = (ones_q == CW'(RUN));

  // R6: a run never grows past the limit, a zero is always inserted first
  a_r6_run_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ones_q <= CW'(RUN));
  a_r6_no_count_on_stuff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stuff_o && !clr_i) |=> ones_q == CW'(RUN));
endmodule

// File: rtl/lapd_tx.sv
module lapd_tx
  import lapd_tx_pkg::*;
#(
  parameter int AW        = 7,
  parameter int LEN_LONG  = 82,
  parameter int LEN_SHORT = 76,
  parameter int RUN       = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [7:0]    wr_data_i,
  input  logic          len_sel_i,
  input  logic          start_i,
  input  logic          bit_req_i,
  output logic          bit_o,
  output logic          busy_o,
  output logic          done_irq_o
);
  tx_state_e     state_q, state_d;
  logic [3:0]    cnt_q, cnt_d;
  logic [AW-1:0] ptr_q, ptr_d, last_q, last_d;
  logic          done_q, done_d;

  logic       busy, start_ok, adv;
  logic [7:0] rd_data;
  logic       flag_bit, data_bit, fcs_bit, stuff, stuff_now, in_zone;
  logic       payload, out_bit;

  assign busy     = (state_q != ST_IDLE);
  assign start_ok = start_i && !busy;
  assign adv      = bit_req_i;

  lapd_msg_ram #(.AW(AW)) u_ram (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (wr_en_i),
    .blk_i   (busy),
    .waddr_i (wr_addr_i),
    .wdata_i (wr_data_i),
    .raddr_i (ptr_q),
    .rdata_o (rd_data)
  );

  assign flag_bit = FLAG_OCTET[cnt_q[2:0]];
  assign data_bit = rd_data[cnt_q[2:0]];
  assign in_zone  = (state_q == ST_DATA) || (state_q == ST_CRC) || (state_q == ST_CLOSE);
  assign stuff_now = stuff && in_zone;
  assign payload  = (state_q == ST_DATA) ? data_bit : fcs_bit;

  always_comb begin
    unique case (state_q)
      ST_DATA, ST_CRC: out_bit = stuff ? 1'b0 : payload;
      ST_CLOSE:        out_bit = stuff ? 1'b0 : flag_bit;
      default:         out_bit = flag_bit;
    endcase
  end

  lapd_crc16 u_crc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .init_i    (start_ok),
    .upd_i     (adv && (state_q == ST_DATA) && !stuff),
    .bit_i     (data_bit),
    .shift_i   (adv && (state_q == ST_CRC) && !stuff),
    .fcs_bit_o (fcs_bit)
  );

  lapd_zero_stuff #(.RUN(RUN)) u_stuff (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (start_ok || (adv && stuff_now)),
    .upd_i   (adv && ((state_q == ST_DATA) || (state_q == ST_CRC)) && !stuff),
    .bit_i   (payload),
    .stuff_o (stuff)
  );

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    ptr_d   = ptr_q;
    last_d  = last_q;
    done_d  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_ok) begin
          state_d = ST_OPEN;
          cnt_d   = '0;
          last_d  = len_sel_i ? AW'(LEN_LONG - 1) : AW'(LEN_SHORT - 1);
        end else if (adv) begin
          cnt_d = {1'b0, cnt_q[2:0] + 3'd1};
        end
      end
      ST_OPEN: begin
        if (adv) begin
          if (cnt_q == 4'd7) begin
            state_d = ST_DATA;
            cnt_d   = '0;
            ptr_d   = '0;
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
      end
      ST_DATA: begin
        if (adv && !stuff) begin
          if (cnt_q == 4'd7) begin
            cnt_d = '0;
            if (ptr_q == last_q) state_d = ST_CRC;
            else                 ptr_d   = ptr_q + 1'b1;
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
      end
      ST_CRC: begin
        if (adv && !stuff) begin
          if (cnt_q == 4'd15) begin
            state_d = ST_CLOSE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
      end
      ST_CLOSE: begin
        if (adv && !stuff) begin
          if (cnt_q == 4'd7) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
            done_d  = 1'b1;
          end else begin
            cnt_d = cnt_q + 4'd1;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      ptr_q   <= '0;
      last_q  <= AW'(LEN_SHORT - 1);
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      ptr_q   <= ptr_d;
      last_q  <= last_d;
      done_q  <= done_d;
    end
  end

  assign bit_o      = out_bit;
  assign busy_o     = busy;
  assign done_irq_o = done_q;

  a_r7_irq_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |-> !busy_o);
  a_r7_end_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_irq_o);
  a_r7_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_irq_o |=> !done_irq_o);
  a_r8_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bit_req_i && !start_i) |=> $stable(bit_o));
  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && start_i && !bit_req_i) |=> ($stable(state_q) && $stable(cnt_q) && $stable(ptr_q)));
  a_r4_len_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |=> $stable(last_q));
endmodule

// File: tb/lapd_tx_tb_top.sv
`timescale 1ns/1ps
module lapd_tx_tb_top;
  localparam int AW = 7;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [7:0]    wr_data_i = '0;
  logic          len_sel_i = 1'b0;
  logic          start_i = 1'b0;
  logic          bit_req_i = 1'b0;
  logic          bit_o, busy_o, done_irq_o;

  always #2.5 clk_i = ~clk_i;

  lapd_tx #(.AW(AW)) dut_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en_i),
    .wr_addr_i  (wr_addr_i),
    .wr_data_i  (wr_data_i),
    .len_sel_i  (len_sel_i),
    .start_i    (start_i),
    .bit_req_i  (bit_req_i),
    .bit_o      (bit_o),
    .busy_o     (busy_o),
    .done_irq_o (done_irq_o)
  );

  typedef struct {
    logic  b;
    logic  irq;
    string tag;
  } exp_t;

  exp_t       exp_q[$];
  int         checks = 0;
  int         errors = 0;
  int         ones_m = 0;
  bit         finished = 0;
  logic [7:0] model_mem [128];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] crc_step(logic [15:0] c, logic b);
    logic fb = c[0] ^ b;
    c = c >> 1;
    if (fb) c = c ^ 16'h8408;
    return c;
  endfunction

  function automatic void push_flag(string tag, bit irq_last);
    logic [7:0] f = 8'h7E;
    for (int i = 0; i < 8; i++) exp_q.push_back('{f[i], (irq_last && i == 7), tag});
  endfunction

  function automatic void push_stuffed(logic b, string tag);
    exp_q.push_back('{b, 1'b0, tag});
    if (b) ones_m++; else ones_m = 0;
    if (ones_m == 5) begin
      exp_q.push_back('{1'b0, 1'b0, "R6"});
      ones_m = 0;
    end
  endfunction

  // scoreboard driver: expected stream for one message
  function automatic void push_frame(int n, string dtag);
    logic [15:0] c = 16'hFFFF;
    push_flag("R3", 0);
    ones_m = 0;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        c = crc_step(c, model_mem[k][i]);
        push_stuffed(model_mem[k][i], dtag);
      end
    c = ~c;
    for (int i = 0; i < 16; i++) push_stuffed(c[i], "R5");
    push_flag("R7", 1);
    push_flag("R7", 0);  // idle flags resume from bit 0
  endfunction

  function automatic bit tail_stuffed(int n);
    logic [15:0] c = 16'hFFFF;
    int ones = 0;
    bit last = 0;
    for (int k = 0; k < n; k++)
      for (int i = 0; i < 8; i++) begin
        c = crc_step(c, model_mem[k][i]);
        ones = model_mem[k][i] ? ones + 1 : 0;
        last = (ones == 5);
        if (last) ones = 0;
      end
    c = ~c;
    for (int i = 0; i < 16; i++) begin
      ones = c[i] ? ones + 1 : 0;
      last = (ones == 5);
      if (last) ones = 0;
    end
    return last;
  endfunction

  task automatic write_byte(input int a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = AW'(a); wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic load_msg(input int n);
    for (int k = 0; k < n; k++) write_byte(k, model_mem[k]);
  endtask

  task automatic do_start(input logic sel);
    @(negedge clk_i);
    start_i = 1'b1; len_sel_i = sel;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R3 busy after start", busy_o, 1);
  endtask

  // monitor: pops one expected bit per strobe and compares
  task automatic strobe(input int gap);
    exp_t e;
    logic held = bit_o;
    for (int g = 0; g < gap; g++) begin
      @(negedge clk_i);
      chk(bit_o == held, "R8 hold without strobe", bit_o, held);
      chk(done_irq_o == 1'b0, "R7 no irq in gap", done_irq_o, 0);
    end
    e = exp_q.pop_front();
    chk(bit_o == e.b, e.tag, bit_o, e.b);
    bit_req_i = 1'b1;
    @(negedge clk_i);
    bit_req_i = 1'b0;
    chk(done_irq_o == e.irq, "R7 irq timing", done_irq_o, e.irq);
    if (e.irq) chk(busy_o == 1'b0, "R7 busy low at irq", busy_o, 0);
  endtask

  task automatic drain(input int gmax);
    while (exp_q.size() > 0) strobe($urandom_range(0, gmax));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o == 1'b0, "R1 busy", busy_o, 0);
    chk(done_irq_o == 1'b0, "R1 irq", done_irq_o, 0);
    chk(bit_o == 1'b0, "R1 bit", bit_o, 0);

    push_flag("R2", 0);
    push_flag("R2", 0);
    drain(2);

    // long message, back-to-back strobes
    for (int k = 0; k < 128; k++) model_mem[k] = 8'($urandom);
    load_msg(82);
    do_start(1'b1);
    push_frame(82, "R4 long");
    drain(0);
    chk(busy_o == 1'b0, "R7 idle after message", busy_o, 0);

    // short message, random gaps, start/write/len change inside opening flag
    for (int k = 0; k < 76; k++) model_mem[k] = 8'($urandom);
    load_msg(76);
    do_start(1'b0);
    push_frame(76, "R9/R10");
    for (int i = 0; i < 3; i++) strobe(1);
    write_byte(0, ~model_mem[0]);      // R10 must be discarded
    chk(busy_o == 1'b1, "R10 busy during write", busy_o, 1);
    @(negedge clk_i); start_i = 1'b1; len_sel_i = 1'b1;  // R9 ignored, R4 not resampled
    @(negedge clk_i); start_i = 1'b0;
    drain(3);

    // dense stuffing: all ones
    for (int k = 0; k < 76; k++) model_mem[k] = 8'hFF;
    load_msg(76);
    do_start(1'b0);
    push_frame(76, "R6 ones");
    drain(1);

    // stuffed zero right before closing flag
    begin
      bit found = 0;
      for (int k = 0; k < 82; k++) model_mem[k] = 8'($urandom);
      for (int v = 0; v < 256 && !found; v++) begin
        model_mem[81] = 8'(v);
        found = tail_stuffed(82);
      end
      chk(found, "R6 tail case found", found, 1);
    end
    load_msg(82);
    do_start(1'b1);
    push_frame(82, "R6 tail");
    drain(0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(150000 * 5);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule